// File: doc/BRIEF.md
# Prescaled Wide Free-Running Counter

This block is a wide event counter, 64 bits by default, that must add one on every enabled clock at a clock rate where a single full-width increment cannot settle in one period. A narrow low field runs on every enabled cycle. A wide upper field loads its incremented value only on the cycle in which the low field rolls over. Between two such loads the upper adder's inputs do not change for several cycles, so its carry chain can be timed as a multicycle path.

The count output comes straight from the registers of both fields, so it is correct on every cycle. No wait state is inserted and no stale value ever appears. A parameter selects a second arrangement instead. In that arrangement the counter is split into two equal halves: the carry out of the low half is registered, the low half is delayed by one stage, and the two halves meet again at the output one cycle later. A one-cycle wrap pulse marks each rollover of the full value from all ones to zero.

Top module: `wcnt_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register is cleared: after that edge `count_o` reads zero and `wrap_o` reads zero. Reset is synchronous and active low.
- R2: With `ARCH` = 0 (prescaled), each rising edge that samples `en_i` high makes `count_o` read one more than before, modulo 2^CNT_W, directly after that edge.
- R3: An edge that samples `en_i` low leaves the count unchanged and raises no wrap pulse.
- R4: The upper field `count_o[CNT_W-1:LO_W]` changes only when the preceding value of the low field `count_o[LO_W-1:0]` was all ones.
- R5: `wrap_o` is high for exactly one cycle: the cycle in which `count_o` has just gone from all ones to zero. It is low at every other time.
- R6: With `ARCH` = 1 (split halves), `count_o` and `wrap_o` equal the values that the prescaled variant would show one cycle earlier. The output therefore lags the enable by one edge.
- R7: If the enable is dropped while the low field is all ones, the upper field does not advance. When counting resumes, the next enabled edge carries into the upper field.
- R8: A reset applied while a registered carry is pending in the split variant discards that carry. The count stays at zero until enabled edges arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Count enable; the counter advances on edges where it is high |
| count_o | output | CNT_W | Current count value |
| wrap_o | output | 1 | One-cycle pulse on rollover from all ones to zero |

## Verification
The bench builds two instances with `CNT_W` = 12 and `LO_W` = 2, one for each `ARCH` value. The narrow width lets a full rollover happen within about four thousand cycles, so the wrap pulse and the carry out of the upper field into nothing are exercised for real rather than assumed. With a 12-bit width the split variant has 6-bit halves. A pending carry between the halves can therefore be set up quickly and then hit with a reset, and the one-cycle lag of that variant can be compared edge for edge against the prescaled one.

// File: rtl/wcnt_pkg.sv
// Shared definitions for the wide counter.
// Assumes nothing beyond a single clock domain.
package wcnt_pkg;

    // Selects how the wide increment is broken up
    typedef enum logic {
        ARCH_PRESCALE = 1'b0,   // narrow low field gates the wide upper field
        ARCH_SPLIT    = 1'b1    // two halves with a registered carry between them
    } arch_e;

endpackage

// File: rtl/wcnt_lo_ctr.sv
// Narrow free-running field counter.
// Advances by one on every enabled edge and reports, combinationally,
// that the current edge will roll it over (enabled and at all ones).
// Assumes: synchronous active-low reset; W >= 1.
module wcnt_lo_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    output logic [W-1:0] q_o,
    output logic         roll_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] q_r;

    // Step the field on enabled edges
    always_ff @(posedge clk) begin
        if (!rst_n)    q_r <= '0;
        else if (en_i) q_r <= q_r + ONE;
    end

    assign q_o    = q_r;
    assign roll_o = en_i & (&q_r);

endmodule

// File: rtl/wcnt_hi_ctr.sv
// Wide upper field counter.
// Loads its incremented value only when inc_i is high. The adder's inputs
// stay constant between loads, which is what allows a multicycle budget.
// full_o flags the all-ones state so that a rollover can be detected.
// Assumes: synchronous active-low reset; W >= 1.
module wcnt_hi_ctr #(
    parameter int W = 62
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] q_o,
    output logic         full_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] q_r;
    logic [W-1:0] q_next;

    // Incremented value; its inputs only change at a load
    always_comb q_next = q_r + ONE;

    // Capture the incremented value under the load enable
    always_ff @(posedge clk) begin
        if (!rst_n)     q_r <= '0;
        else if (inc_i) q_r <= q_next;
    end

    assign q_o    = q_r;
    assign full_o = &q_r;

endmodule

// File: rtl/wcnt_prescale.sv
// Prescaled arrangement: a LO_W-bit low field runs on every enabled edge.
// The upper field advances only on the edge where the low field rolls over.
// The output is taken from the registers directly, with no latency.
// Assumes: synchronous active-low reset; 1 <= LO_W < CNT_W.
module wcnt_prescale #(
    parameter int CNT_W = 64,
    parameter int LO_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    localparam int HI_W = CNT_W - LO_W;

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            lo_roll;
    logic            hi_full;
    logic            wrap_r;

    wcnt_lo_ctr #(.W(LO_W)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .q_o    (lo_q),
        .roll_o (lo_roll)
    );

    wcnt_hi_ctr #(.W(HI_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (lo_roll),
        .q_o    (hi_q),
        .full_o (hi_full)
    );

    // Flag the edge on which the whole value rolls over
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_r <= 1'b0;
        else        wrap_r <= lo_roll & hi_full;
    end

    assign count_o = {hi_q, lo_q};
    assign wrap_o  = wrap_r;

endmodule

// File: rtl/wcnt_split.sv
// Split-halves arrangement: the low half counts on enabled edges and its
// carry out is registered. The upper half adds that carry one edge later.
// The low half is delayed one stage so that both halves line up, which
// gives the output a latency of one edge.
// Assumes: synchronous active-low reset; CNT_W >= 2.
module wcnt_split #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    localparam int LO_H = CNT_W / 2;
    localparam int HI_H = CNT_W - LO_H;

    logic [LO_H-1:0] lo_q;
    logic [LO_H-1:0] lo_dly;
    logic [HI_H-1:0] hi_q;
    logic            lo_roll;
    logic            carry_r;
    logic            hi_full;
    logic            wrap_r;

    wcnt_lo_ctr #(.W(LO_H)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .q_o    (lo_q),
        .roll_o (lo_roll)
    );

    // Register the carry out of the low half and delay the low half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_r <= 1'b0;
            lo_dly  <= '0;
        end else begin
            carry_r <= lo_roll;
            lo_dly  <= lo_q;
        end
    end

    wcnt_hi_ctr #(.W(HI_H)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (carry_r),
        .q_o    (hi_q),
        .full_o (hi_full)
    );

    // Flag the rollover when the delayed carry leaves the upper half
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_r <= 1'b0;
        else        wrap_r <= carry_r & hi_full;
    end

    assign count_o = {hi_q, lo_dly};
    assign wrap_o  = wrap_r;

endmodule

// File: rtl/wcnt_top.sv
// Wide free-running counter, top level.
// ARCH selects the prescaled arrangement (zero latency) or the split-halves
// arrangement (one edge of latency). Both clear on a synchronous
// active-low reset.
// Assumes: 1 <= LO_W < CNT_W; LO_W only matters for the prescaled variant.
module wcnt_top #(
    parameter int              CNT_W = 64,
    parameter int              LO_W  = 2,
    parameter wcnt_pkg::arch_e ARCH  = wcnt_pkg::ARCH_PRESCALE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    // Pick the variant at elaboration time
    if (ARCH == wcnt_pkg::ARCH_PRESCALE) begin : g_pre
        wcnt_prescale #(.CNT_W(CNT_W), .LO_W(LO_W)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_i),
            .count_o (count_o),
            .wrap_o  (wrap_o)
        );
    end else begin : g_split
        wcnt_split #(.CNT_W(CNT_W)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_i),
            .count_o (count_o),
            .wrap_o  (wrap_o)
        );
    end

endmodule

// File: rtl/wcnt_chk.sv
// Property checker for wcnt_top, bound to every instance of it.
// Observes only the ports. The expected lag of the output (0 or 1 edge)
// follows from ARCH.
module wcnt_chk #(
    parameter int              CNT_W = 64,
    parameter int              LO_W  = 2,
    parameter wcnt_pkg::arch_e ARCH  = wcnt_pkg::ARCH_PRESCALE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic [CNT_W-1:0] count_o,
    input logic             wrap_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic pv1 = 1'b0;
    logic pv2 = 1'b0;

    // Track how many edges have passed, so that $past is never read too early
    always_ff @(posedge clk) begin
        pv1 <= 1'b1;
        pv2 <= pv1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        (pv1 && !$past(rst_n)) |-> (count_o == '0 && !wrap_o));

    // R5
    wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv1 && $past(rst_n)) |-> (wrap_o == ((count_o == '0) && (&$past(count_o)))));

    // R4
    upper_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv1 && $past(rst_n) && (count_o[CNT_W-1:LO_W] != $past(count_o[CNT_W-1:LO_W])))
        |-> (&$past(count_o[LO_W-1:0])));

    if (ARCH == wcnt_pkg::ARCH_PRESCALE) begin : g_pre
        // R2
        step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pv1 && $past(rst_n) && $past(en_i)) |-> (count_o == $past(count_o) + ONE));
        // R3
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pv1 && $past(rst_n) && !$past(en_i)) |-> ($stable(count_o) && !wrap_o));
    end else begin : g_split
        // R6
        lag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pv2 && $past(rst_n) && $past(rst_n, 2) && $past(en_i, 2))
            |-> (count_o == $past(count_o) + ONE));
        // R3
        lag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pv2 && $past(rst_n) && $past(rst_n, 2) && !$past(en_i, 2))
            |-> ($stable(count_o) && !wrap_o));
    end

endmodule

bind wcnt_top wcnt_chk #(.CNT_W(CNT_W), .LO_W(LO_W), .ARCH(ARCH)) u_wcnt_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .count_o (count_o),
    .wrap_o  (wrap_o)
);

// File: tb/tb_wcnt_top.sv
`timescale 1ns/1ps
module tb_wcnt_top;

    localparam int W = 12;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic [W-1:0] cnt_pre, cnt_spl;
    logic         wrap_pre, wrap_spl;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [W-1:0] exp_pre = '0;
    logic         exp_pre_w = 1'b0;
    logic [W-1:0] exp_spl = '0;
    logic         exp_spl_w = 1'b0;

    // {en, expected prescaled count after the edge}, starting from zero
    localparam logic [12:0] VEC [16] = '{
        13'h1001, 13'h1002, 13'h1003, 13'h0003,
        13'h1004, 13'h1005, 13'h0005, 13'h0005,
        13'h1006, 13'h1007, 13'h1008, 13'h1009,
        13'h0009, 13'h100A, 13'h100B, 13'h100C
    };

    always #2 clk = ~clk;

    wcnt_top #(.CNT_W(W), .LO_W(2), .ARCH(wcnt_pkg::ARCH_PRESCALE)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .count_o(cnt_pre), .wrap_o(wrap_pre));

    wcnt_top #(.CNT_W(W), .LO_W(2), .ARCH(wcnt_pkg::ARCH_SPLIT)) dut_split (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .count_o(cnt_spl), .wrap_o(wrap_spl));

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock edge with the given reset and enable, then model update
    task automatic tick(input logic rn, input logic e);
        rst_n = rn;
        en_i  = e;
        @(posedge clk);
        #1;
        if (!rn) begin
            exp_pre = '0; exp_pre_w = 1'b0; exp_spl = '0; exp_spl_w = 1'b0;
        end else begin
            exp_spl   = exp_pre;
            exp_spl_w = exp_pre_w;
            exp_pre_w = e && (exp_pre == MAXV);
            if (e) exp_pre = exp_pre + 1'b1;
        end
    endtask

    task automatic check_all(input string req);
        check(req, "prescaled count", cnt_pre, exp_pre);
        check(req, "prescaled wrap", {{(W-1){1'b0}}, wrap_pre}, {{(W-1){1'b0}}, exp_pre_w});
        check("R6", "split count", cnt_spl, exp_spl);
        check("R6", "split wrap", {{(W-1){1'b0}}, wrap_spl}, {{(W-1){1'b0}}, exp_spl_w});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset clears both variants
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b1);
        check_all("R1");

        // R2 and R3: table of enable patterns and expected counts
        foreach (VEC[i]) begin
            tick(1'b1, VEC[i][12]);
            check(VEC[i][12] ? "R2" : "R3", "table count", cnt_pre, VEC[i][W-1:0]);
            check_all("R2");
        end

        // R7: stop with the low field at all ones (count 15)
        repeat (3) tick(1'b1, 1'b1);
        check("R7", "count at low all ones", cnt_pre, 12'd15);
        repeat (3) begin
            tick(1'b1, 1'b0);
            check("R7", "upper field held", {2'b00, cnt_pre[W-1:2]}, 12'd3);
            check("R3", "no wrap while held", {{(W-1){1'b0}}, wrap_pre}, '0);
        end
        // R4: resuming carries into the upper field
        tick(1'b1, 1'b1);
        check("R4", "upper field after resume", {2'b00, cnt_pre[W-1:2]}, 12'd4);
        check("R4", "low field after resume", {10'd0, cnt_pre[1:0]}, 12'd0);
        check_all("R4");

        // R8: reset while the split variant holds a carry
        tick(1'b0, 1'b0);
        repeat (64) tick(1'b1, 1'b1);
        check_all("R2");
        tick(1'b0, 1'b1);
        check("R8", "split count on reset", cnt_spl, 12'd0);
        repeat (2) begin
            tick(1'b1, 1'b0);
            check("R8", "split count after reset", cnt_spl, 12'd0);
            check_all("R8");
        end

        // R5: run the full range and through the rollover
        for (int n = 0; n < 4095; n++) begin
            tick(1'b1, 1'b1);
            check_all("R2");
        end
        check("R5", "count at all ones", cnt_pre, MAXV);
        tick(1'b1, 1'b1);
        check("R5", "count after rollover", cnt_pre, 12'd0);
        check("R5", "wrap pulse", {{(W-1){1'b0}}, wrap_pre}, 12'd1);
        check_all("R5");
        tick(1'b1, 1'b1);
        check("R5", "wrap ends", {{(W-1){1'b0}}, wrap_pre}, 12'd0);
        check("R6", "split wrap lags", {{(W-1){1'b0}}, wrap_spl}, 12'd1);
        check_all("R5");
        tick(1'b1, 1'b0);
        check_all("R3");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule